// File: doc/BRIEF.md
# Power-Up Reset Sequencer

This block runs on the slow always-on clock and brings a small system out of power-on in a fixed order. It holds everything in reset while the asynchronous power-on detector reports low supply. Once that input is released it lets the slow oscillator settle for a counted number of cycles, then switches the core regulator on. It waits for the core supply monitor to report a valid level for a full clock cycle and releases the core-domain reset. A further counted delay later it releases the peripheral and processor resets together, and the processor reset is never released ahead of the others.

After start-up the block keeps supervising. If the core supply monitor drops, all three domain resets are pulled back and the sequence returns to qualification, and the regulator stays on throughout. An external reset pin pulls back only the processor and peripheral resets. When the pin is released, the post-core delay runs again. A status output shows the current sequencing step.

Top module: `pwr_seq`

## Requirements
- R1: While `porN` is low, `regEn`, `coreRstN`, `cpuRstN` and `perRstN` are 0 and `seqState` is 0. This takes effect asynchronously, with no clock edge needed.
- R2: After `porN` rises between clock edges, `regEn` stays 0 through the first 7 rising edges and becomes 1 on the 8th. The 8 edges are two synchronizer edges, one start edge and SETTLE_CYC = 5 settle edges. At that point `seqState` is 2.
- R3: Once `regEn` is 1 it stays 1 until `porN` goes low, including during brownout recovery.
- R4: In the qualify step, `coreRstN` is released on a rising edge only when `coreOk` was 1 at that edge and at the edge before it. A single-edge pulse of `coreOk` does not release it.
- R5: `cpuRstN` and `perRstN` rise together on the DELAY_CYC-th rising edge (default 3) after the edge that released `coreRstN`. `seqState` is then 4.
- R6: `cpuRstN` is never 1 while `coreRstN`, `perRstN` or `regEn` is 0.
- R7: If `coreOk` is 0 at a rising edge while `coreRstN` is 1, then at that edge `coreRstN`, `cpuRstN` and `perRstN` all go to 0 and `seqState` becomes 2.
- R8: If `extRstN` is 0 at a rising edge while `coreRstN` is 1 and `coreOk` is 1, then at that edge `cpuRstN` and `perRstN` go to 0, `coreRstN` stays 1 and `seqState` becomes 5.
- R9: In the hold step, the first rising edge that sees `extRstN` at 1 moves to the delay step (`seqState` 3). `cpuRstN` and `perRstN` are released DELAY_CYC edges after that edge.
- R10: The `seqState` encoding is 0 reset, 1 settle, 2 qualify, 3 delay, 4 run and 5 hold. No other value appears.
- R11: When `coreOk` and `extRstN` are both 0 at the same edge, the brownout response of R7 takes precedence and `seqState` becomes 2.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Slow always-on clock |
| porN | input | 1 | Asynchronous active-low power-on reset |
| coreOk | input | 1 | Core supply valid flag from the brownout monitor |
| extRstN | input | 1 | External reset pin, active low |
| regEn | output | 1 | Regulator enable (shutdown pin drive), active high |
| coreRstN | output | 1 | Core-domain reset, active low |
| cpuRstN | output | 1 | Processor reset, active low; released last |
| perRstN | output | 1 | Peripheral reset, active low |
| seqState | output | 3 | Current sequencing step code |

## Verification
The properties assume that `coreOk` and `extRstN` change only away from rising clock edges, so they are sampled cleanly without a synchronizer. They also assume that `porN` is the only input that acts asynchronously. The bench changes every input on the falling edge and reads outputs on the falling edge after the edges it counts. The one exception is the mid-run power-on drop, which is checked a nanosecond after `porN` falls, still between edges.

// File: rtl/pwr_seq_pkg.sv
package pwr_seq_pkg;

  typedef enum logic [2:0] {
    ST_RESET  = 3'd0,
    ST_SETTLE = 3'd1,
    ST_QUAL   = 3'd2,
    ST_DELAY  = 3'd3,
    ST_RUN    = 3'd4,
    ST_HOLD   = 3'd5
  } seqState_e;

  typedef struct packed {
    logic cntClr;
    logic cntInc;
    logic regOn;
    logic coreRel;
    logic coreHold;
    logic appRel;
    logic appHold;
  } seqCmd_t;

endpackage

// File: rtl/pwr_seq_sync.sv
module pwr_seq_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic asyncN,
  output logic syncN
);

  logic [STAGES-1:0] chain;

  always_ff @(posedge clk or negedge asyncN) begin
    if (!asyncN) chain <= '0;
    else         chain <= {chain[STAGES-2:0], 1'b1};
  end

  assign syncN = chain[STAGES-1];

endmodule

// File: rtl/pwr_seq_ctrl.sv
module pwr_seq_ctrl
  import pwr_seq_pkg::*;
(
  input  logic      clk,
  input  logic      rstN,
  input  logic      coreOk,
  input  logic      coreOkQ,
  input  logic      extRstN,
  input  logic      settleHit,
  input  logic      delayHit,
  output seqCmd_t   cmd,
  output seqState_e state
);

  seqState_e nextState;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) state <= ST_RESET;
    else       state <= nextState;
  end

  always_comb begin
    nextState = state;
    cmd       = '0;
    unique case (state)
      ST_RESET: begin
        nextState  = ST_SETTLE;
        cmd.cntClr = 1'b1;
      end
      ST_SETTLE: begin
        if (settleHit) begin
          nextState  = ST_QUAL;
          cmd.regOn  = 1'b1;
          cmd.cntClr = 1'b1;
        end else begin
          cmd.cntInc = 1'b1;
        end
      end
      ST_QUAL: begin
        if (coreOk && coreOkQ) begin
          nextState   = ST_DELAY;
          cmd.coreRel = 1'b1;
          cmd.cntClr  = 1'b1;
        end
      end
      ST_DELAY: begin
        if (!coreOk) begin
          nextState    = ST_QUAL;
          cmd.coreHold = 1'b1;
          cmd.appHold  = 1'b1;
        end else if (!extRstN) begin
          nextState   = ST_HOLD;
          cmd.appHold = 1'b1;
        end else if (delayHit) begin
          nextState  = ST_RUN;
          cmd.appRel = 1'b1;
        end else begin
          cmd.cntInc = 1'b1;
        end
      end
      ST_RUN: begin
        if (!coreOk) begin
          nextState    = ST_QUAL;
          cmd.coreHold = 1'b1;
          cmd.appHold  = 1'b1;
        end else if (!extRstN) begin
          nextState   = ST_HOLD;
          cmd.appHold = 1'b1;
        end
      end
      ST_HOLD: begin
        if (!coreOk) begin
          nextState    = ST_QUAL;
          cmd.coreHold = 1'b1;
          cmd.appHold  = 1'b1;
        end else if (extRstN) begin
          nextState  = ST_DELAY;
          cmd.cntClr = 1'b1;
        end
      end
      default: begin
        nextState = ST_RESET;
      end
    endcase
  end

endmodule

// File: rtl/pwr_seq_dp.sv
module pwr_seq_dp
  import pwr_seq_pkg::*;
#(
  parameter int SETTLE_CYC = 5,
  parameter int DELAY_CYC  = 3,
  parameter int CNT_W      = 3
) (
  input  logic    clk,
  input  logic    rstN,
  input  logic    coreOk,
  input  seqCmd_t cmd,
  output logic    coreOkQ,
  output logic    settleHit,
  output logic    delayHit,
  output logic    regEn,
  output logic    coreRstN,
  output logic    cpuRstN,
  output logic    perRstN
);

  localparam logic [CNT_W-1:0] SETTLE_LAST = CNT_W'(SETTLE_CYC - 1);
  localparam logic [CNT_W-1:0] DELAY_LAST  = CNT_W'(DELAY_CYC - 1);

  logic [CNT_W-1:0] cnt;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)           cnt <= '0;
    else if (cmd.cntClr) cnt <= '0;
    else if (cmd.cntInc) cnt <= cnt + 1'b1;
  end

  assign settleHit = (cnt == SETTLE_LAST);
  assign delayHit  = (cnt == DELAY_LAST);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) coreOkQ <= 1'b0;
    else       coreOkQ <= coreOk;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)          regEn <= 1'b0;
    else if (cmd.regOn) regEn <= 1'b1;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)             coreRstN <= 1'b0;
    else if (cmd.coreHold) coreRstN <= 1'b0;
    else if (cmd.coreRel)  coreRstN <= 1'b1;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)            perRstN <= 1'b0;
    else if (cmd.appHold) perRstN <= 1'b0;
    else if (cmd.appRel)  perRstN <= 1'b1;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)            cpuRstN <= 1'b0;
    else if (cmd.appHold) cpuRstN <= 1'b0;
    else if (cmd.appRel)  cpuRstN <= 1'b1;
  end

endmodule

// File: rtl/pwr_seq.sv
module pwr_seq
  import pwr_seq_pkg::*;
#(
  parameter int SETTLE_CYC  = 5,
  parameter int DELAY_CYC   = 3,
  parameter int SYNC_STAGES = 2
) (
  input  logic       clk,
  input  logic       porN,
  input  logic       coreOk,
  input  logic       extRstN,
  output logic       regEn,
  output logic       coreRstN,
  output logic       cpuRstN,
  output logic       perRstN,
  output logic [2:0] seqState
);

  localparam int MAX_CYC = (SETTLE_CYC > DELAY_CYC) ? SETTLE_CYC : DELAY_CYC;
  localparam int CNT_W   = (MAX_CYC < 2) ? 1 : $clog2(MAX_CYC);

  logic      sysRstN;
  logic      coreOkQ;
  logic      settleHit;
  logic      delayHit;
  seqCmd_t   cmd;
  seqState_e state;

  pwr_seq_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk    (clk),
    .asyncN (porN),
    .syncN  (sysRstN)
  );

  pwr_seq_ctrl u_ctrl (
    .clk       (clk),
    .rstN      (sysRstN),
    .coreOk    (coreOk),
    .coreOkQ   (coreOkQ),
    .extRstN   (extRstN),
    .settleHit (settleHit),
    .delayHit  (delayHit),
    .cmd       (cmd),
    .state     (state)
  );

  pwr_seq_dp #(
    .SETTLE_CYC (SETTLE_CYC),
    .DELAY_CYC  (DELAY_CYC),
    .CNT_W      (CNT_W)
  ) u_dp (
    .clk       (clk),
    .rstN      (sysRstN),
    .coreOk    (coreOk),
    .cmd       (cmd),
    .coreOkQ   (coreOkQ),
    .settleHit (settleHit),
    .delayHit  (delayHit),
    .regEn     (regEn),
    .coreRstN  (coreRstN),
    .cpuRstN   (cpuRstN),
    .perRstN   (perRstN)
  );

  assign seqState = state;

endmodule

// File: rtl/pwr_seq_chk.sv
module pwr_seq_chk (
  input logic       clk,
  input logic       porN,
  input logic       coreOk,
  input logic       extRstN,
  input logic       regEn,
  input logic       coreRstN,
  input logic       cpuRstN,
  input logic       perRstN,
  input logic [2:0] seqState
);

  AST_REG_STICKY: assert property (@(posedge clk) disable iff (!porN)
    regEn |=> regEn); // R3

  AST_CORE_QUALIFIED: assert property (@(posedge clk) disable iff (!porN)
    $rose(coreRstN) |-> ($past(coreOk) && $past(coreOk, 2))); // R4

  AST_APP_AFTER_CORE: assert property (@(posedge clk) disable iff (!porN)
    $rose(cpuRstN) |-> $past(coreRstN)); // R5

  AST_CPU_LAST: assert property (@(posedge clk) disable iff (!porN)
    cpuRstN |-> (coreRstN && perRstN && regEn)); // R6

  AST_BROWNOUT_DROP: assert property (@(posedge clk) disable iff (!porN)
    (coreRstN && !coreOk) |=> (!coreRstN && !cpuRstN && !perRstN && seqState == 3'd2)); // R7

  AST_PIN_HOLD: assert property (@(posedge clk) disable iff (!porN)
    (coreRstN && coreOk && !extRstN) |=> (coreRstN && !cpuRstN && !perRstN)); // R8

  AST_STATE_LEGAL: assert property (@(posedge clk) disable iff (!porN)
    seqState <= 3'd5); // R10

endmodule

bind pwr_seq pwr_seq_chk u_chk (
  .clk      (clk),
  .porN     (porN),
  .coreOk   (coreOk),
  .extRstN  (extRstN),
  .regEn    (regEn),
  .coreRstN (coreRstN),
  .cpuRstN  (cpuRstN),
  .perRstN  (perRstN),
  .seqState (seqState)
);

// File: tb/pwr_seq_test.sv
module pwr_seq_test;

  logic       clk = 1'b0;
  logic       porN = 1'b0;
  logic       coreOk = 1'b1;
  logic       extRstN = 1'b1;
  logic       regEn, coreRstN, cpuRstN, perRstN;
  logic [2:0] seqState;

  int errors = 0;
  int checks = 0;
  bit done   = 1'b0;

  always #2 clk = ~clk;

  pwr_seq uut (
    .clk      (clk),
    .porN     (porN),
    .coreOk   (coreOk),
    .extRstN  (extRstN),
    .regEn    (regEn),
    .coreRstN (coreRstN),
    .cpuRstN  (cpuRstN),
    .perRstN  (perRstN),
    .seqState (seqState)
  );

  task automatic chk(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic step(input int n);
    for (int i = 0; i < n; i++) begin
      @(posedge clk);
      @(negedge clk);
    end
  endtask

  task automatic chkOuts(input string tag, input int r, input int c, input int p, input int s);
    chk({tag, " regEn"}, regEn, r);
    chk({tag, " coreRstN"}, coreRstN, c);
    chk({tag, " cpu/per"}, {cpuRstN, perRstN}, p ? 3 : 0);
    chk({tag, " seqState"}, seqState, s);
  endtask

  task automatic testReset();
    step(3);
    chkOuts("R1 held in reset", 0, 0, 0, 0);
  endtask

  task automatic testPowerUp();
    porN = 1'b1;
    step(7);
    chk("R2 regEn before settle done", regEn, 0);
    step(1);
    chk("R2 regEn after settle", regEn, 1);
    chk("R10 qualify code", seqState, 2);
    step(1);
    chk("R4 core released with steady coreOk", coreRstN, 1);
    chk("R10 delay code", seqState, 3);
    step(2);
    chk("R5 cpu still held", cpuRstN, 0);
    step(1);
    chkOuts("R5 full release", 1, 1, 1, 4);
  endtask

  task automatic testLateCore();
    porN = 1'b0;
    #1;
    chkOuts("R1 async drop mid-run", 0, 0, 0, 0);
    @(negedge clk);
    coreOk = 1'b0;
    porN = 1'b1;
    step(12);
    chk("R4 core held while coreOk low", coreRstN, 0);
    chk("R2 regEn on", regEn, 1);
    coreOk = 1'b1;
    step(1);
    coreOk = 1'b0;
    step(2);
    chk("R4 single-edge pulse ignored", coreRstN, 0);
    coreOk = 1'b1;
    step(1);
    chk("R4 one edge is not enough", coreRstN, 0);
    step(1);
    chk("R4 release on second edge", coreRstN, 1);
    step(3);
    chk("R5 release after late core", cpuRstN, 1);
  endtask

  task automatic testBrownout();
    coreOk = 1'b0;
    step(1);
    chkOuts("R7 brownout drop", 1, 0, 0, 2);
    step(2);
    chk("R3 regEn kept", regEn, 1);
    coreOk = 1'b1;
    step(2);
    chk("R7 core requalified", coreRstN, 1);
    step(2);
    chk("R6 cpu waits", cpuRstN, 0);
    step(1);
    chkOuts("R5 release after recovery", 1, 1, 1, 4);
  endtask

  task automatic testPin();
    extRstN = 1'b0;
    step(1);
    chkOuts("R8 pin hold", 1, 1, 0, 5);
    step(4);
    chkOuts("R8 pin still held", 1, 1, 0, 5);
    extRstN = 1'b1;
    step(1);
    chkOuts("R9 delay restarts", 1, 1, 0, 3);
    step(2);
    chk("R9 still held", cpuRstN, 0);
    step(1);
    chkOuts("R9 released", 1, 1, 1, 4);
  endtask

  task automatic testBoth();
    extRstN = 1'b0;
    coreOk  = 1'b0;
    step(1);
    chkOuts("R11 brownout wins", 1, 0, 0, 2);
    coreOk  = 1'b1;
    extRstN = 1'b1;
    step(2);
    chk("R11 core back", coreRstN, 1);
    step(3);
    chkOuts("R11 full release", 1, 1, 1, 4);
  endtask

  initial begin
    @(negedge clk);
    testReset();
    testPowerUp();
    testLateCore();
    testBrownout();
    testPin();
    testBoth();
    if (!done) begin
      done = 1'b1;
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    #(200000 * 4);
    if (!done) begin
      done = 1'b1;
      errors++;
      checks++;
      $display("FAIL watchdog: actual=timeout expected=finish");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

endmodule